// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This is a memory-mapped watchdog peripheral on a plain register bus: an address, a write strobe, write data and combinational read data. A down-counter runs from a programmable reload value. The first time it reaches zero, it raises a pending interrupt and starts again from the reload value. If software has not serviced that interrupt when the counter reaches zero a second time, and the reset stage is armed, a system reset output asserts and stays asserted.

Software keeps the system alive by writing the interrupt-clear register. That write drops the pending interrupt and restarts the count. A 32-bit key written to the lock register opens the other registers for writing. Any other value closes them again, so stray writes cannot disarm the watchdog.

Top module: `wdog_timer`

## Requirements
- R1: After rst_ni, reload (0x000) reads 0xFFFFFFFF, control (0x008) reads 0, lock (0xC00) reads 0 (unlocked), and irq_o and sys_rst_o are low.
- R2: An unlocked write to the reload register at 0x000 stores the value and loads the counter with it on the same clock edge.
- R3: With control bit 0 set, the counter decrements once per clock. At the first edge after it reaches zero, the pending interrupt sets and the counter restarts from reload. So from a count C, the interrupt rises C+1 edges after counting is enabled.
- R4: When the counter reaches zero while the interrupt is pending and control bit 1 is set, sys_rst_o asserts one edge later. This is reload+1 edges after the interrupt rose. sys_rst_o then stays high until rst_ni.
- R5: When control bit 1 is clear, further expiries leave sys_rst_o low and the interrupt pending.
- R6: Any unlocked write to 0x00C, whatever the data, clears the pending interrupt and reloads the counter from reload. Regular writes there keep sys_rst_o low.
- R7: Bit 0 of 0x010 shows the pending interrupt. Bit 0 of 0x014 shows the pending interrupt ANDed with control bit 0. irq_o equals the bit at 0x014.
- R8: While control bit 0 is clear, the count read at 0x004 does not change.
- R9: Writing 0x1ACCE551 to 0xC00 unlocks, and any other value locks. The lock register reads 1 while locked. While locked, writes to every other register are ignored.
- R10: The identification register at 0xFE0 reads 0x00141805.
- R11: The count register at 0x004 is read-only: writes to it leave the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 12 | Register byte address |
| we_i | input | 1 | Write strobe, sampled at the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | Masked interrupt |
| sys_rst_o | output | 1 | Sticky system reset request |

## Verification
Register writes take effect at the edge that samples the strobe. Read data follows the address within the same cycle. The bench therefore reads 1 ns after it changes the address, and samples each result at the falling edge after the write. Expiry timing is measured by counting falling edges after the write that enables counting. The interrupt is expected after C+1 edges, and the reset after a further reload+1. Both intervals are computed from the programmed values, and each is checked with randomly drawn reload values as well as the minimum reload of 1.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int AW = 12;
  localparam int DW = 32;

  localparam logic [AW-1:0] A_RELOAD = 12'h000;
  localparam logic [AW-1:0] A_COUNT  = 12'h004;
  localparam logic [AW-1:0] A_CTRL   = 12'h008;
  localparam logic [AW-1:0] A_CLR    = 12'h00C;
  localparam logic [AW-1:0] A_RAW    = 12'h010;
  localparam logic [AW-1:0] A_MSK    = 12'h014;
  localparam logic [AW-1:0] A_LOCK   = 12'hC00;
  localparam logic [AW-1:0] A_ID     = 12'hFE0;

  localparam logic [DW-1:0] UNLOCK_KEY = 32'h1ACCE551;
  localparam logic [DW-1:0] ID_VAL     = 32'h00141805;

  // bit 1: reset stage armed, bit 0: count + interrupt enable
  typedef struct packed {
    logic rst_en;
    logic run_en;
  } ctrl_t;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  output logic          locked_o,
  output ctrl_t         ctrl_o,
  output logic [CW-1:0] reload_o,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          clr_o
);
  logic wr_ok;

  assign wr_ok = we_i && !locked_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_o <= 1'b0;
      ctrl_o   <= '0;
      reload_o <= '1;
    end else begin
      if (we_i && addr_i == A_LOCK) locked_o <= (wdata_i != UNLOCK_KEY);
      if (wr_ok && addr_i == A_CTRL) ctrl_o <= ctrl_t'(wdata_i[1:0]);
      if (wr_ok && addr_i == A_RELOAD) reload_o <= wdata_i[CW-1:0];
    end
  end

  assign clr_o      = wr_ok && addr_i == A_CLR;
  assign load_o     = clr_o || (wr_ok && addr_i == A_RELOAD);
  // reload write takes effect on the counter in the same edge
  assign load_val_o = (addr_i == A_RELOAD) ? wdata_i[CW-1:0] : reload_o;
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          rst_en_i,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic [CW-1:0] reload_i,
  input  logic          clr_i,
  output logic [CW-1:0] count_o,
  output logic          pend_o,
  output logic          sys_rst_o
);
  logic expire;

  assign expire = run_i && !load_i && (count_o == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o   <= '1;
      pend_o    <= 1'b0;
      sys_rst_o <= 1'b0;
    end else begin
      if (load_i)          count_o <= load_val_i;
      else if (expire)     count_o <= reload_i;
      else if (run_i)      count_o <= count_o - 1'b1;

      if (clr_i)           pend_o <= 1'b0;
      else if (expire)     pend_o <= 1'b1;

      if (expire && pend_o && rst_en_i) sys_rst_o <= 1'b1;
    end
  end
endmodule

// File: rtl/wdog_rdmux.sv
module wdog_rdmux
  import wdog_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic          locked_i,
  input  ctrl_t         ctrl_i,
  input  logic [CW-1:0] reload_i,
  input  logic [CW-1:0] count_i,
  input  logic          pend_i,
  output logic [DW-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_RELOAD: rdata_o[CW-1:0] = reload_i;
      A_COUNT:  rdata_o[CW-1:0] = count_i;
      A_CTRL:   rdata_o[1:0]    = ctrl_i;
      A_RAW:    rdata_o[0]      = pend_i;
      A_MSK:    rdata_o[0]      = pend_i & ctrl_i.run_en;
      A_LOCK:   rdata_o[0]      = locked_i;
      A_ID:     rdata_o         = ID_VAL;
      default:  rdata_o         = '0;
    endcase
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [11:0]   addr_i,
  input  logic          we_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          irq_o,
  output logic          sys_rst_o
);
  logic          locked_q;
  ctrl_t         ctrl_q;
  logic [CW-1:0] reload_q;
  logic          load;
  logic [CW-1:0] load_val;
  logic          clr;
  logic [CW-1:0] count_q;
  logic          pend_q;

  wdog_regs #(.CW(CW)) u_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .locked_o(locked_q), .ctrl_o(ctrl_q), .reload_o(reload_q),
    .load_o(load), .load_val_o(load_val), .clr_o(clr)
  );

  wdog_counter #(.CW(CW)) u_cnt (
    .clk_i, .rst_ni,
    .run_i(ctrl_q.run_en), .rst_en_i(ctrl_q.rst_en),
    .load_i(load), .load_val_i(load_val), .reload_i(reload_q), .clr_i(clr),
    .count_o(count_q), .pend_o(pend_q), .sys_rst_o
  );

  wdog_rdmux #(.CW(CW)) u_rd (
    .addr_i, .locked_i(locked_q), .ctrl_i(ctrl_q), .reload_i(reload_q),
    .count_i(count_q), .pend_i(pend_q), .rdata_o
  );

  assign irq_o = pend_q & ctrl_q.run_en;
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk
  import wdog_pkg::*;
#(
  parameter int CW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [11:0]   addr_i,
  input logic          we_i,
  input logic [31:0]   wdata_i,
  input logic          irq_o,
  input logic          sys_rst_o,
  input logic          locked,
  input logic [1:0]    ctrl,
  input logic [CW-1:0] reload,
  input logic [CW-1:0] count,
  input logic          pend
);
  AST_RST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_rst_o |=> sys_rst_o); // R4

  AST_RST_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_o) |-> ($past(pend) && $past(ctrl[1]) && $past(count) == '0)); // R4

  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked && we_i && addr_i != A_LOCK) |=> ($stable(reload) && $stable(ctrl))); // R9

  AST_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl[0] && !(we_i && !locked && (addr_i == A_RELOAD || addr_i == A_CLR)))
      |=> $stable(count)); // R8

  AST_CLR_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !locked && addr_i == A_CLR) |=> !pend); // R6

  AST_RELOAD_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !locked && addr_i == A_RELOAD) |=> count == $past(wdata_i[CW-1:0])); // R2

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend && ctrl[0])); // R7
endmodule

bind wdog_timer wdog_timer_chk #(.CW(CW)) u_chk (
  .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i, .irq_o, .sys_rst_o,
  .locked(locked_q), .ctrl(ctrl_q), .reload(reload_q),
  .count(count_q), .pend(pend_q)
);

// File: tb/wdog_timer_bench.sv
module wdog_timer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  logic        sys_rst_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  localparam logic [11:0] RL = 12'h000, CT = 12'h004, CR = 12'h008, CL = 12'h00C;
  localparam logic [11:0] RW = 12'h010, MK = 12'h014, LK = 12'hC00, IDA = 12'hFE0;

  wdog_timer u_wdog_timer (.*);

  always #10 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  function automatic int irq_due(input int c);
    return c + 1;
  endfunction

  function automatic int rst_due(input int c, input int r);
    return c + 1 + r + 1;
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c1, c2;
    int n, ni;
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    rd(RL, d); chk("R1 reload", d, 32'hFFFFFFFF);
    rd(CR, d); chk("R1 ctrl", d, 0);
    rd(LK, d); chk("R1 lock", d, 0);
    chk("R1 irq", irq_o, 0);
    chk("R1 sys_rst", sys_rst_o, 0);
    // R10
    rd(IDA, d); chk("R10 id", d, 32'h00141805);

    // R2 / R11
    wr(RL, 100);
    rd(CT, d); chk("R2 count", d, 100);
    rd(RL, d); chk("R2 reload", d, 100);
    wr(CT, 55);
    rd(CT, d); chk("R11 count ro", d, 100);

    // R3 / R7 / R8 random
    for (int it = 0; it < 12; it++) begin
      int r;
      r = $urandom_range(40, 1);
      wr(CR, 0);
      wr(CL, $urandom);
      wr(RL, r);
      wr(CR, 1);
      n = 0;
      while (!irq_o && n < 1000) begin @(negedge clk_i); n++; end
      chk("R3 irq delay", n, irq_due(r));
      rd(CT, d); chk("R3 restart count", d, r);
      rd(RW, d); chk("R7 raw", d, 1);
      rd(MK, d); chk("R7 masked", d, 1);
      wr(CR, 0);
      chk("R7 irq masked off", irq_o, 0);
      rd(MK, d); chk("R7 masked off", d, 0);
      rd(RW, d); chk("R7 raw kept", d, 1);
      rd(CT, c1);
      repeat ($urandom_range(8, 2)) @(negedge clk_i);
      rd(CT, c2); chk("R8 stopped", c2, c1);
    end

    // R6 clear
    wr(CL, 0);
    rd(RW, d); chk("R6 clr raw", d, 0);
    rd(CT, d); rd(RL, c1); chk("R6 clr reload", d, c1);

    // R5 no reset stage
    wr(RL, 5); wr(CR, 1);
    repeat (30) @(negedge clk_i);
    chk("R5 no rst", sys_rst_o, 0);
    rd(RW, d); chk("R5 pending", d, 1);
    wr(CR, 0); wr(CL, 0);

    // R9 lock
    wr(RL, 20);
    wr(LK, 1);
    rd(LK, d); chk("R9 locked", d, 1);
    wr(RL, 7);
    rd(RL, d); chk("R9 reload ignored", d, 20);
    rd(CT, d); chk("R9 count ignored", d, 20);
    wr(CR, 3);
    rd(CR, d); chk("R9 ctrl ignored", d, 0);
    wr(LK, 32'h1ACCE550);
    rd(LK, d); chk("R9 near key locks", d, 1);
    wr(LK, 32'h1ACCE551);
    rd(LK, d); chk("R9 unlocked", d, 0);

    // R6 keep-alive
    wr(RL, 10); wr(CL, 0); wr(CR, 3);
    for (int k = 0; k < 8; k++) begin
      repeat (6) @(negedge clk_i);
      wr(CL, $urandom);
    end
    chk("R6 keepalive rst", sys_rst_o, 0);
    chk("R6 keepalive irq", irq_o, 0);

    // R4 minimum reload, both stages
    wr(CR, 0); wr(CL, 0); wr(RL, 1); wr(CR, 3);
    n = 0; ni = -1;
    while (!sys_rst_o && n < 1000) begin
      @(negedge clk_i); n++;
      if (irq_o && ni < 0) ni = n;
    end
    chk("R4 irq at", ni, irq_due(1));
    chk("R4 rst at", n, rst_due(1, 1));
    wr(CR, 0); wr(CL, 0);
    repeat (5) @(negedge clk_i);
    chk("R4 sticky", sys_rst_o, 1);

    rst_ni = 1'b0; @(negedge clk_i); rst_ni = 1'b1; @(negedge clk_i);
    chk("R1 rst cleared", sys_rst_o, 0);

    // R4 random reload
    begin
      int r;
      r = $urandom_range(30, 2);
      wr(RL, r); wr(CR, 3);
      n = 0;
      while (!sys_rst_o && n < 1000) begin @(negedge clk_i); n++; end
      chk("R4 rst delay", n, rst_due(r, r));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule